// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a free-running watchdog meant to sit on the 32.768 kHz low-speed clock of a small controller. Once out of reset it counts with no enable. If software lets a full period go by without servicing it, the block raises a non-maskable interrupt request. If a second full period then also passes without service, it issues a one-cycle system reset request and sets a sticky flag. The flag survives that reset, so boot code can see why the chip restarted.

Software services the watchdog by writing an unlock byte and then a trigger byte through a small write port. A valid service zeroes the counter and drops the interrupt request. The 2-bit period select picks one of four overflow periods, each four times longer than the one before. The counter takes a new select value only at a cycle where its count is zero, so a period already under way is never shortened or stretched.

Top module: `wdt_two_stage`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `nmi_req`, `rst_req` and `wdt_rst_flag` are all 0.
- R2: Select code k (0 to 3) gives an overflow period of 2^(BASE_LOG2+2k) clock cycles. With the default BASE_LOG2 = 12 this is 4096, 16384, 65536 or 262144 cycles, which is 125 ms, 500 ms, 2 s or 8 s at 32.768 kHz.
- R3: The first overflow with no service since the previous overflow, reset or service sets `nmi_req`. It stays at 1 until a service or the second overflow.
- R4: An overflow while `nmi_req` is 1 drives `rst_req` to 1 for exactly one cycle and clears `nmi_req`. Escalation then starts over, so the next overflow raises `nmi_req` again.
- R5: A service is a write of 0x5A (`clr_we`=1) followed, as the next write, by a write of 0xA5. Cycles without a write may come between the two. On the clock edge of the 0xA5 write the counter returns to zero and `nmi_req` clears.
- R6: A 0xA5 write with no pending 0x5A has no effect. Any write other than 0x5A or 0xA5 cancels a pending 0x5A. A repeated 0x5A keeps the sequence pending.
- R7: `period_sel` is sampled only on a clock edge where the count is zero. A change made while the count is non-zero does not affect the running period.
- R8: `wdt_rst_flag` goes to 1 together with `rst_req` and stays at 1 until `sts_clr` is asserted. If both happen in the same cycle, setting wins.
- R9: If a service lands on the very cycle the counter would overflow, the service wins: no escalation happens and a fresh period starts.
- R10: The counter runs from the first edge after reset release with no enable. Left alone after reset, the block raises `nmi_req` after one period and `rst_req` after two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-speed counting clock |
| rst | input | 1 | Synchronous active-high reset |
| period_sel | input | 2 | Overflow period code |
| clr_we | input | 1 | Service write strobe |
| clr_data | input | 8 | Service write byte |
| sts_clr | input | 1 | Clears the sticky watchdog-reset flag |
| nmi_req | output | 1 | Non-maskable interrupt request (level) |
| rst_req | output | 1 | One-cycle system reset request |
| wdt_rst_flag | output | 1 | Sticky record of a watchdog reset request |

## Verification
There are two collisions. The first is a service whose 0xA5 write falls on the same edge as an overflow. The bench provokes it by counting from a known service, so that the 0x5A write moves the count to its last value and the 0xA5 write lands on the overflow edge. It then checks that `nmi_req` stays low and that the next interrupt comes exactly one full period later. The second is a status clear held during the cycle of the second overflow. The bench checks that `wdt_rst_flag` reads 1 alongside the reset pulse and drops only on the following cycle.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam logic [7:0] KEY_ARM  = 8'h5A;
    localparam logic [7:0] KEY_FIRE = 8'hA5;

    typedef enum logic {
        UL_IDLE  = 1'b0,
        UL_ARMED = 1'b1
    } unlock_st_e;

    typedef struct packed {
        logic stage1;
        logic rst_pulse;
        logic sticky;
    } esc_state_t;

    // Overflow period for a select code: each step is four times longer.
    function automatic int unsigned period_cycles(input int unsigned base_log2,
                                                  input logic [1:0]  sel);
        int unsigned sh;
        sh = base_log2 + 2 * 32'(sel);
        return 32'd1 << sh;
    endfunction

endpackage

// File: rtl/wdg_unlock.sv
module wdg_unlock
    import wdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr_we,
    input  logic [7:0] clr_data,
    output logic       svc
);
    unlock_st_e st;

    always_comb svc = (st == UL_ARMED) && clr_we && (clr_data == KEY_FIRE);

    always_ff @(posedge clk) begin
        if (rst)
            st <= UL_IDLE;
        else if (clr_we)
            st <= (clr_data == KEY_ARM) ? UL_ARMED : UL_IDLE;
    end

    // R6: the sequence can only become pending through an unlock write
    assert_arm_source_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(st == UL_ARMED) |-> $past(clr_we && clr_data == KEY_ARM));
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
    import wdg_pkg::*;
#(
    parameter int unsigned BASE_LOG2 = 12,
    localparam int unsigned CNT_W    = BASE_LOG2 + 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] period_sel,
    input  logic       svc,
    output logic       ovf
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic [1:0]       sel_q;
    logic             at_lim;

    always_comb begin
        lim    = CNT_W'(period_cycles(BASE_LOG2, sel_q) - 1);
        at_lim = (cnt == lim);
        ovf    = at_lim && !svc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            sel_q <= '0;
        end else begin
            if (cnt == '0)
                sel_q <= period_sel;
            if (svc || at_lim)
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;
        end
    end

    // R2: the count never passes the selected terminal value
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
        cnt <= lim);
    // R5: a service leaves the count at zero
    assert_svc_zero_R5: assert property (@(posedge clk) disable iff (rst)
        svc |=> (cnt == '0));
    // R7: the latched select holds while a period runs
    assert_sel_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |=> $stable(sel_q));
endmodule

// File: rtl/wdg_escalate.sv
module wdg_escalate
    import wdg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ovf,
    input  logic svc,
    input  logic sts_clr,
    output logic nmi_req,
    output logic rst_req,
    output logic wdt_rst_flag
);
    esc_state_t st;
    logic       second;

    always_comb second = ovf && st.stage1 && !svc;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.rst_pulse <= second;
            if (svc)
                st.stage1 <= 1'b0;
            else if (ovf)
                st.stage1 <= !st.stage1;
            if (second)
                st.sticky <= 1'b1;
            else if (sts_clr)
                st.sticky <= 1'b0;
        end
    end

    always_comb begin
        nmi_req      = st.stage1;
        rst_req      = st.rst_pulse;
        wdt_rst_flag = st.sticky;
    end

    // R3: first overflow raises the interrupt request
    assert_nmi_first_R3: assert property (@(posedge clk) disable iff (rst)
        (ovf && !nmi_req) |=> nmi_req);
    // R4: second overflow resets and restarts escalation
    assert_rst_second_R4: assert property (@(posedge clk) disable iff (rst)
        (ovf && nmi_req) |=> (rst_req && !nmi_req));
    // R4: reset request is one cycle wide
    assert_rst_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);
    // R8: sticky flag is present whenever a reset is requested
    assert_flag_set_R8: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> wdt_rst_flag);
    // R5: a service drops the interrupt request
    assert_svc_clears_R5: assert property (@(posedge clk) disable iff (rst)
        svc |=> !nmi_req);
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
    import wdg_pkg::*;
#(
    parameter int unsigned BASE_LOG2 = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] period_sel,
    input  logic       clr_we,
    input  logic [7:0] clr_data,
    input  logic       sts_clr,
    output logic       nmi_req,
    output logic       rst_req,
    output logic       wdt_rst_flag
);
    logic svc;
    logic ovf;

    wdg_unlock u_unlock (
        .clk      (clk),
        .rst      (rst),
        .clr_we   (clr_we),
        .clr_data (clr_data),
        .svc      (svc)
    );

    wdg_counter #(.BASE_LOG2(BASE_LOG2)) u_counter (
        .clk        (clk),
        .rst        (rst),
        .period_sel (period_sel),
        .svc        (svc),
        .ovf        (ovf)
    );

    wdg_escalate u_escalate (
        .clk          (clk),
        .rst          (rst),
        .ovf          (ovf),
        .svc          (svc),
        .sts_clr      (sts_clr),
        .nmi_req      (nmi_req),
        .rst_req      (rst_req),
        .wdt_rst_flag (wdt_rst_flag)
    );

    // R9: service and overflow never both reach escalation
    assert_svc_wins_R9: assert property (@(posedge clk) disable iff (rst)
        !(svc && ovf));
endmodule

// File: tb/wdt_two_stage_bench.sv
module wdt_two_stage_bench;
    localparam int unsigned BASE = 4;   // periods 16, 64, 256, 1024

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] period_sel = 2'd0;
    logic       clr_we = 1'b0;
    logic [7:0] clr_data = 8'h00;
    logic       sts_clr = 1'b0;
    logic       nmi_req, rst_req, wdt_rst_flag;

    int nvec = 0;
    int nerr = 0;

    always #5 clk = ~clk;

    wdt_two_stage #(.BASE_LOG2(BASE)) u_wdt_two_stage (
        .clk(clk), .rst(rst), .period_sel(period_sel), .clr_we(clr_we),
        .clr_data(clr_data), .sts_clr(sts_clr), .nmi_req(nmi_req),
        .rst_req(rst_req), .wdt_rst_flag(wdt_rst_flag)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        clr_we = 1'b1; clr_data = d;
        tick(1);
        clr_we = 1'b0;
    endtask

    task automatic do_service();
        wr(8'h5A);
        wr(8'hA5);
    endtask

    task automatic do_reset();
        rst = 1'b1; period_sel = 2'd0; sts_clr = 1'b0; clr_we = 1'b0;
        tick(3);
        rst = 1'b0;
    endtask

    // R1: quiet outputs during and right after reset
    task automatic t_reset();
        do_reset();
        chk("R1", "nmi_req", nmi_req, 1'b0);
        chk("R1", "rst_req", rst_req, 1'b0);
        chk("R1", "wdt_rst_flag", wdt_rst_flag, 1'b0);
        tick(1);
        chk("R1", "nmi_req after release", nmi_req, 1'b0);
    endtask

    // R3 R4 R8 R10: unattended escalation from reset
    task automatic t_escalate();
        do_reset();
        tick(15); chk("R10", "nmi before first period", nmi_req, 1'b0);
        tick(1);  chk("R3", "nmi at first overflow", nmi_req, 1'b1);
        tick(15); chk("R3", "nmi held", nmi_req, 1'b1);
                  chk("R4", "no rst before second", rst_req, 1'b0);
        tick(1);  chk("R4", "rst at second overflow", rst_req, 1'b1);
                  chk("R4", "nmi cleared with rst", nmi_req, 1'b0);
                  chk("R8", "flag set", wdt_rst_flag, 1'b1);
        tick(1);  chk("R4", "rst one cycle", rst_req, 1'b0);
        tick(14); chk("R4", "restart: nmi low", nmi_req, 1'b0);
        tick(1);  chk("R4", "restart: nmi again", nmi_req, 1'b1);
                  chk("R8", "flag sticky", wdt_rst_flag, 1'b1);
        sts_clr = 1'b1; tick(1); sts_clr = 1'b0;
        chk("R8", "flag cleared", wdt_rst_flag, 1'b0);
    endtask

    // R5: valid service
    task automatic t_service();
        do_service();
        chk("R5", "nmi cleared by service", nmi_req, 1'b0);
        tick(15); chk("R5", "count restarted", nmi_req, 1'b0);
        tick(1);  chk("R5", "full period after service", nmi_req, 1'b1);
    endtask

    // R6: bad sequences ignored, repeated unlock kept
    task automatic t_bad();
        do_service();
        wr(8'hA5); wr(8'h5A); wr(8'h12); wr(8'hA5);
        tick(11); chk("R6", "bad writes: no early nmi", nmi_req, 1'b0);
        tick(1);  chk("R6", "bad writes did not clear", nmi_req, 1'b1);
        wr(8'h5A); wr(8'h5A); wr(8'hA5);
        chk("R6", "repeated unlock then trigger services", nmi_req, 1'b0);
    endtask

    // R7 R2: select taken only at zero, periods per code
    task automatic t_select();
        do_service();
        tick(1); period_sel = 2'd3;
        tick(14); chk("R7", "mid-period select ignored (low)", nmi_req, 1'b0);
        tick(1);  chk("R7", "mid-period select ignored (ovf)", nmi_req, 1'b1);
        period_sel = 2'd1;
        do_service();
        tick(63); chk("R2", "code1 before 64", nmi_req, 1'b0);
        tick(1);  chk("R2", "code1 at 64", nmi_req, 1'b1);
        period_sel = 2'd3;
        do_service();
        tick(1023); chk("R2", "code3 before 1024", nmi_req, 1'b0);
        tick(1);    chk("R2", "code3 at 1024", nmi_req, 1'b1);
        period_sel = 2'd0;
        do_service();
    endtask

    // R9: service on the overflow edge
    task automatic t_collide();
        do_service();
        tick(14);
        wr(8'h5A);
        wr(8'hA5);
        chk("R9", "service beats overflow", nmi_req, 1'b0);
        tick(15); chk("R9", "fresh period low", nmi_req, 1'b0);
        tick(1);  chk("R9", "fresh period ovf", nmi_req, 1'b1);
    endtask

    // R8: clear and set in the same cycle
    task automatic t_flag_collide();
        do_reset();
        tick(31);
        sts_clr = 1'b1;
        tick(1);
        chk("R8", "rst with clear held", rst_req, 1'b1);
        chk("R8", "set wins over clear", wdt_rst_flag, 1'b1);
        tick(1);
        chk("R8", "clear next cycle", wdt_rst_flag, 1'b0);
        sts_clr = 1'b0;
    endtask

    initial begin
        t_reset();
        t_escalate();
        t_service();
        t_bad();
        t_select();
        t_collide();
        t_flag_collide();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nvec++; nerr++;
        $display("FAIL R10 watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule